// File: doc/BRIEF.md
# Two-Wire Indexed Register Target

This block is a target-only endpoint for the two-wire I2C serial bus. It gives an external controller access to a byte-wide register file through an internal index pointer. Two strap inputs choose one of four device addresses. The block watches clock and data lines that arrive asynchronously. It pulls the data line low only through an open-drain enable. Toward the chip it offers a plain register-file port: an address, write data, a one-cycle write strobe and combinational read data.

To write a register, the controller sends the device address with the direction bit clear, then the register index, then the data byte. To read a register, the controller sends the index the same way, issues a repeated START, sends the device address with the direction bit set, and clocks out one byte. It ends the read with a NACK and a STOP. The block does not stretch the clock, does not answer general calls, does not handle 10-bit addresses and does not arbitrate between controllers.

Top module: `i2c_idx_slave`

## Requirements
- R1: A falling data line while the clock line is high (START) aborts any transfer in progress, releases the data line and starts a new address byte. A rising data line while the clock is high (STOP) releases the line and returns the block to idle.
- R2: The address byte matches when its upper seven bits equal binary 10011 followed by `dev_sel[1]` and then `dev_sel[0]`. Bit 0 is the direction bit: 0 means write and 1 means read. With `dev_sel` = 00 the address bytes are 98h/99h, with 10 they are 9Ch/9Dh, and with 11 they are 9Eh/9Fh.
- R3: The block acknowledges a matching address byte, the index byte and every write data byte by holding the data line low for the whole ninth clock pulse.
- R4: After an address byte that does not match, the block leaves the ninth clock unacknowledged. It then ignores all further bytes, with no acknowledge and no write strobe, until the next START.
- R5: For each data byte received in a write transfer, `reg_we` pulses high for exactly one clock. During that clock `reg_addr` holds the index and `reg_wdata` holds the byte. The strobe comes after the eighth data bit has been sampled and before the acknowledge is driven. Further data bytes in the same transfer write the same index.
- R6: After a matching read address, the block sends the register selected by the index, MSB first. It keeps the data line released during the acknowledge slot that follows. A controller ACK (line low) makes it send the same register again. A NACK makes it idle.
- R7: The open-drain enable changes only while the clock line is low, except for the release on START or STOP.
- R8: Bits are taken MSB first. Each bit is sampled on the rising clock-line edge, after a two-stage synchronizer.
- R9: While reset is held, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel | input | 2 | Strap pins choosing the device address |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| sda_in | input | 1 | Bus data line (asynchronous) |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| reg_addr | output | 8 | Register-file address (the index pointer) |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle register-file write strobe |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
The hardest states to reach are the aborted ones. The first is a START that arrives partway through a byte, after only some bits have been shifted in. The second is a STOP that lands between the index byte and the data byte, which must leave the pointer moved but nothing written. The stimulus creates these by driving the bus lines directly: a few data bits, then a repeated START; or an index byte, then a STOP. It then reads back a neighbouring register and the aborted one to show that no stray write took place. A second hard case is a controller ACK after read data. The bench gives that ACK and expects the same byte to be sent again.

// File: rtl/i2cs_pkg.sv
// Shared constants and state encoding for the two-wire register target.
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting in the device address byte
        ST_INDEX,     // shifting in the register index
        ST_WDATA,     // shifting in write data
        ST_ACK_WAIT,  // byte complete, waiting for SCL low to drive ACK
        ST_ACK,       // driving ACK through the ninth clock
        ST_TX,        // shifting out read data
        ST_TX_ACK     // line released, observing controller ACK/NACK
    } state_t;
endpackage

// File: rtl/i2cs_sync.sv
// Multi-stage synchronizer for asynchronous bus lines.
// Assumes STAGES >= 2; idle bus level (high) is the reset value.
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        // shift the raw line through the flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], d[g]};
        end
        assign q[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/i2cs_bus_cond.sv
// Detects clock edges and START/STOP conditions on synchronized lines.
// Assumes inputs are already synchronous to clk; outputs are one-cycle pulses.
module i2cs_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q;

    // hold previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
// Byte engine: address match, ACK generation, index pointer, write strobe
// and read data shifting. Assumes one-cycle edge/condition pulses and no
// clock stretching; SDA is only driven low through sda_oe.
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int          REG_AW = 8,
    parameter logic [4:0]  DEV_HI = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sda_bit,
    input  logic [SEL_W-1:0]  dev_sel,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    state_t            state, after;
    logic [BYTE_W-1:0] sh, idx;
    logic [2:0]        cnt;
    logic              mack;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_end, dev_hit;

    assign rx_byte  = {sh[BYTE_W-2:0], sda_bit};
    assign byte_end = scl_rise && (cnt == 3'd7);
    assign dev_hit  = (rx_byte[BYTE_W-1:1] == {DEV_HI, dev_sel});
    assign reg_addr = idx[REG_AW-1:0];

    // main transfer sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after     <= ST_IDLE;
            sh        <= '0;
            idx       <= '0;
            cnt       <= '0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_evt) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_evt) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: if (scl_rise) begin
                        sh  <= rx_byte;
                        cnt <= cnt + 3'd1;
                        if (byte_end) begin
                            if (!dev_hit) state <= ST_IDLE;
                            else begin
                                state <= ST_ACK_WAIT;
                                after <= rx_byte[0] ? ST_TX : ST_INDEX;
                            end
                        end
                    end
                    ST_INDEX: if (scl_rise) begin
                        sh  <= rx_byte;
                        cnt <= cnt + 3'd1;
                        if (byte_end) begin
                            idx   <= rx_byte;
                            after <= ST_WDATA;
                            state <= ST_ACK_WAIT;
                        end
                    end
                    ST_WDATA: if (scl_rise) begin
                        sh  <= rx_byte;
                        cnt <= cnt + 3'd1;
                        if (byte_end) begin
                            reg_we    <= 1'b1;
                            reg_wdata <= rx_byte;
                            after     <= ST_WDATA;
                            state     <= ST_ACK_WAIT;
                        end
                    end
                    ST_ACK_WAIT: if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                    end
                    ST_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (after == ST_TX) begin
                            sh     <= reg_rdata;
                            sda_oe <= ~reg_rdata[BYTE_W-1];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= after;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            sda_oe <= ~sh[BYTE_W-2];
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack <= ~sda_bit;
                        if (scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                sh     <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // SDA enable moves only with SCL low, apart from START/STOP release
    assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) && !$past(start_evt) && !$past(stop_evt) |-> !$past(scl_lvl));
    // write strobe is a single pulse, issued before ACK is driven
    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_we_before_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !sda_oe);
    // START restarts address reception with the line released
    assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR) && !sda_oe);
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE) && !sda_oe);
    // the controller's acknowledge slot after read data is never driven
    assert_tx_ack_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK) |-> !sda_oe);
endmodule

// File: rtl/i2c_idx_slave.sv
// Top of the two-wire indexed register target. Synchronizes the bus lines,
// derives edges and bus conditions, and runs the byte engine.
// Assumes REG_AW <= 8 and a register file with combinational read data.
module i2c_idx_slave
    import i2cs_pkg::*;
#(
    parameter int         REG_AW      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_HI      = 5'b10011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dev_sel,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    input  logic [7:0]        reg_rdata
);
    logic [1:0] lines_s;
    logic scl_rise, scl_fall, start_evt, stop_evt;

    i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
    );

    i2cs_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2cs_engine #(.REG_AW(REG_AW), .DEV_HI(DEV_HI)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(lines_s[1]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .sda_bit(lines_s[0]),
        .dev_sel(dev_sel), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );
endmodule

// File: tb/i2c_idx_slave_bench.sv
// Scoreboard bench: driver tasks push expected writes into a queue, a
// monitor pops them on each write strobe; read data is checked in the driver.
module i2c_idx_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dev_sel = 2'b00;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    logic [15:0] exp_q [$];
    int n_chk = 0, n_bad = 0, r7_viol = 0;
    logic prev_oe = 1'b0, prev_scl = 1'b1;
    bit done = 0;
    localparam int Q = 10;

    always #2.5 clk = ~clk;

    i2c_idx_slave u_i2c_idx_slave (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .scl_in(scl_m),
        .sda_in(sda_line), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes (R5) and tracks enable changes (R7)
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) check(0, "R5 unexpected write strobe", {reg_addr, reg_wdata}, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
            end
            check(sda_oe == 1'b0, "R5 strobe before ACK", sda_oe, 0);
        end
        if (rst_n && sda_oe != prev_oe && scl_m && prev_scl) r7_viol++;
        prev_oe  = sda_oe;
        prev_scl = scl_m;
    end

    task automatic tick(input int n); repeat (n) @(posedge clk); #1; endtask
    task automatic bus_start();  sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q); endtask
    task automatic bus_rstart(); sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q); endtask
    task automatic bus_stop();   sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q); endtask
    task automatic clk_bit(input bit b, output bit seen);
        sda_m = b; tick(Q); scl_m = 1; tick(Q); seen = sda_line; tick(Q); scl_m = 0; tick(Q);
    endtask
    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = !s;
    endtask
    task automatic recv_byte(output logic [7:0] b, input bit master_ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
        sda_m = !master_ack; tick(Q); scl_m = 1; tick(Q);
        check(sda_oe == 1'b0, "R6 ack slot released", sda_oe, 0);
        tick(Q); scl_m = 0; tick(Q); sda_m = 1;
    endtask

    task automatic write_txn(input logic [7:0] wa, idx, dat, input bit hit);
        bit a;
        bus_start();
        send_byte(wa, a);  check(a == hit, hit ? "R3 addr ack" : "R4 addr nack", a, hit);
        send_byte(idx, a); check(a == hit, hit ? "R3 index ack" : "R4 index ignored", a, hit);
        if (hit) begin exp_q.push_back({idx, dat}); ref_mem[idx] = dat; end
        send_byte(dat, a); check(a == hit, hit ? "R3 data ack" : "R4 data ignored", a, hit);
        bus_stop();
    endtask

    task automatic read_txn(input logic [7:0] wa, idx, input int nrd);
        bit a;
        logic [7:0] d;
        bus_start();
        send_byte(wa, a);  check(a, "R2 write addr match", a, 1);
        send_byte(idx, a); check(a, "R3 index ack", a, 1);
        bus_rstart();
        send_byte(wa | 8'h01, a); check(a, "R2 read addr match", a, 1);
        for (int k = 0; k < nrd; k++) begin
            recv_byte(d, k < nrd - 1);
            check(d == ref_mem[idx], "R6 R8 read data", d, ref_mem[idx]);
        end
        bus_stop();
    endtask

    initial begin
        bit a, s;
        for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h3C; ref_mem[i] = 8'(i) ^ 8'h3C; end
        tick(10);
        check(sda_oe == 0 && reg_we == 0, "R9 reset outputs", {sda_oe, reg_we}, 0);
        check(reg_addr == 0, "R9 reset index", reg_addr, 0);
        rst_n = 1; tick(10);

        // R3 R5 basic write and R6 readback at 98h/99h
        write_txn(8'h98, 8'h0F, 8'hF0, 1);
        read_txn(8'h98, 8'h0F, 1);
        write_txn(8'h98, 8'h55, 8'h01, 1);   // R8 asymmetric patterns
        write_txn(8'h98, 8'h56, 8'h80, 1);
        read_txn(8'h98, 8'h55, 1);
        read_txn(8'h98, 8'h56, 1);

        // R6 controller ACK repeats the same register
        read_txn(8'h98, 8'h0F, 2);

        // R5 extra data byte writes the same index
        bus_start();
        send_byte(8'h98, a); check(a, "R3 addr ack", a, 1);
        send_byte(8'h30, a); check(a, "R3 index ack", a, 1);
        exp_q.push_back({8'h30, 8'h11});
        send_byte(8'h11, a); check(a, "R3 data ack", a, 1);
        exp_q.push_back({8'h30, 8'h22}); ref_mem[8'h30] = 8'h22;
        send_byte(8'h22, a); check(a, "R5 second data ack", a, 1);
        bus_stop();
        read_txn(8'h98, 8'h30, 1);

        // R1 STOP between index and data: no write
        bus_start();
        send_byte(8'h98, a); send_byte(8'h40, a);
        bus_stop();
        read_txn(8'h98, 8'h40, 1);

        // R1 START part-way through a byte restarts address reception
        bus_start();
        send_byte(8'h98, a);
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
        bus_rstart();
        send_byte(8'h98, a); check(a, "R1 restart addr ack", a, 1);
        send_byte(8'h22, a);
        exp_q.push_back({8'h22, 8'h5A}); ref_mem[8'h22] = 8'h5A;
        send_byte(8'h5A, a); check(a, "R1 restart data ack", a, 1);
        bus_stop();
        read_txn(8'h98, 8'h22, 1);

        // R2 R4 select 10 -> 9Ch: 98h ignored, 9Ch accepted
        dev_sel = 2'b10; tick(4);
        write_txn(8'h98, 8'h10, 8'hEE, 0);
        read_txn(8'h9C, 8'h10, 1);
        write_txn(8'h9C, 8'h10, 8'h81, 1);
        read_txn(8'h9C, 8'h10, 1);
        bus_start();
        send_byte(8'h99, a); check(!a, "R4 foreign read addr nack", a, 0);
        bus_stop();

        // R2 select 11 -> 9Eh
        dev_sel = 2'b11; tick(4);
        write_txn(8'h9E, 8'h77, 8'hC3, 1);
        read_txn(8'h9E, 8'h77, 1);

        tick(20);
        check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
        check(r7_viol == 0, "R7 enable changed with SCL high", r7_viol, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule